// File: doc/BRIEF.md
# USB OUT Endpoint Receive Handler

This block handles the device side of a USB OUT transaction once the token has been decoded upstream. When a token arrives, it compares the token's address with the device's own address. It checks that the endpoint number is one it serves and that this endpoint is enabled. It then looks at the endpoint's buffer-full flag. From these it picks one of three behaviours for the data phase that follows:

- store the bytes into the endpoint FIFO;
- consume them and answer NAK;
- consume them silently.

When the packet closes with a good flag and nothing overflowed, the block does four things. It commits the FIFO contents. It asks the transmitter for an ACK, unless the endpoint is isochronous. It marks the endpoint buffer as full. It raises a pending bit in an interrupt register. The interrupt line is the OR of all pending bits. For an isochronous endpoint there is no handshake phase, so the status and interrupt bits are set one cycle earlier than for a handshaking endpoint.

A microprocessor uses a small register port. It reads the interrupt register, which clears the register, to learn which endpoint needs service. It reads the status register to see which buffers are full. After draining a buffer, it writes a clear mask so that the endpoint can accept the next OUT packet.

The received byte stream uses valid/ready, and so does the FIFO write port.

- Outside the data phase, `rx_ready` is low.
- In the data phase of a storing transaction, `rx_ready` follows `fifo_wr_ready`, so FIFO back-pressure stalls the byte stream.
- When nothing is being written (NAK, skip, or after an overflow), bytes are consumed freely.
- `pkt_end` must be given in a cycle with `rx_valid` low.

Top module: `usb_out_rx_handler`

## Requirements
- R1: A token whose address differs from `dev_addr`, or whose endpoint number is not below NUM_EP, causes no FIFO write, no handshake, and no change to the status or interrupt registers.
- R2: A token for an endpoint whose `ep_enable` bit is 0 causes no FIFO write, no handshake, and no register change.
- R3: For an enabled endpoint whose buffer-full bit is 0, every accepted data byte is presented on the FIFO write port in order. `fifo_wr_ep` carries the endpoint number.
- R4: A good packet stored on a non-isochronous endpoint pulses `hs_ack` and `fifo_commit` for one cycle, in the cycle after the edge that samples `pkt_end`.
- R5: An isochronous endpoint (`ep_iso` bit 1) never gets a handshake. After a good stored packet, its buffer-full and pending bits are visible in the cycle right after the `pkt_end` edge.
- R6: For a non-isochronous endpoint, the buffer-full and pending bits become visible one cycle after the ACK pulse, which is two cycles after the `pkt_end` edge.
- R7: If the endpoint's buffer-full bit is set, no byte is written. A non-isochronous endpoint answers a good packet with a one-cycle `hs_nak`. An isochronous endpoint answers with nothing.
- R8: A packet that ends with `pkt_good` low pulses `fifo_drop` if bytes were being stored. It sends no handshake, even on a NAK endpoint, and leaves the status and interrupt registers unchanged.
- R9: Bytes beyond BUF_BYTES in one packet are consumed but not written. That packet is then handled as a bad one: drop, no handshake, no register change.
- R10: A read with `reg_sel` = 0 returns the pending mask on `reg_rdata` in the next cycle and clears the mask. A pending bit set in the same cycle as the read survives it. `irq` is high whenever any pending bit is set.
- R11: A read with `reg_sel` = 1 returns the buffer-full mask. A write with `reg_clr_en` clears the buffer-full bits set in `reg_clr_mask`, and the endpoint then stores again.
- R12: `rx_ready` is low outside a data phase. During a storing data phase it equals `fifo_wr_ready`. During a NAK or skip data phase it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_addr | input | ADDR_W | Address assigned to this device |
| ep_enable | input | NUM_EP | Per-endpoint enable |
| ep_iso | input | NUM_EP | Per-endpoint isochronous type |
| tok_valid | input | 1 | One-cycle strobe: decoded OUT token |
| tok_addr | input | ADDR_W | Token address field |
| tok_ep | input | 4 | Token endpoint field |
| rx_valid | input | 1 | Data byte valid |
| rx_ready | output | 1 | Data byte accepted when high with rx_valid |
| rx_data | input | 8 | Data byte |
| pkt_end | input | 1 | One-cycle strobe: data phase finished |
| pkt_good | input | 1 | Packet integrity result, sampled with pkt_end |
| fifo_wr_valid | output | 1 | FIFO write request |
| fifo_wr_ready | input | 1 | FIFO can take a byte |
| fifo_wr_ep | output | EPW | Endpoint of the write, commit or drop |
| fifo_wr_data | output | 8 | Byte to write |
| fifo_commit | output | 1 | Pulse: keep the packet just written |
| fifo_drop | output | 1 | Pulse: discard the packet just written |
| hs_ack | output | 1 | Pulse: send ACK |
| hs_nak | output | 1 | Pulse: send NAK |
| reg_rd_en | input | 1 | Register read strobe |
| reg_sel | input | 1 | 0 = interrupt register, 1 = status register |
| reg_rdata | output | NUM_EP | Read data, valid the cycle after reg_rd_en |
| reg_clr_en | input | 1 | Buffer-full clear strobe |
| reg_clr_mask | input | NUM_EP | Endpoints whose buffer-full bit is cleared |
| irq | output | 1 | Interrupt line to the processor |

## Verification
The bench builds the block with NUM_EP = 4 and BUF_BYTES = 8. Endpoint 3 is disabled and endpoint 2 is isochronous, so one run covers the disabled, isochronous and handshaking paths side by side. The small buffer lets a ten-byte packet reach the overflow path within a few cycles. The four endpoints are exactly what two index bits can address, so a token with endpoint number 5 tests the range check on the wider token field. One case lines up a read of the interrupt register with the edge that sets a new pending bit, to show the new bit is not lost.

// File: rtl/uorx_pkg.sv
package uorx_pkg;
  typedef enum logic [1:0] {
    MODE_SKIP  = 2'd0,
    MODE_STORE = 2'd1,
    MODE_NAK   = 2'd2
  } rx_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DATA = 2'd1,
    ST_POST = 2'd2
  } rx_state_e;

  localparam logic SEL_PENDING = 1'b0;
  localparam logic SEL_FULL    = 1'b1;
endpackage

// File: rtl/uorx_token_filter.sv
module uorx_token_filter
  import uorx_pkg::*;
#(
  parameter int NUM_EP = 4,
  parameter int ADDR_W = 7,
  localparam int EPW   = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
  input  logic [ADDR_W-1:0] dev_addr,
  input  logic [ADDR_W-1:0] tok_addr,
  input  logic [3:0]        tok_ep,
  input  logic [NUM_EP-1:0] ep_enable,
  input  logic [NUM_EP-1:0] ep_iso,
  input  logic [NUM_EP-1:0] ep_full,
  output rx_mode_e          mode,
  output logic              iso
);
  logic           addr_ok;
  logic           ep_ok;
  logic [EPW-1:0] idx;

  assign idx = tok_ep[EPW-1:0];

  always_comb begin
    addr_ok = (tok_addr == dev_addr);
    ep_ok   = ({28'd0, tok_ep} < 32'(NUM_EP));
    mode    = MODE_SKIP;
    iso     = 1'b0;
    if (addr_ok && ep_ok && ep_enable[idx]) begin
      iso = ep_iso[idx];
      if (!ep_full[idx])   mode = MODE_STORE;
      else if (!ep_iso[idx]) mode = MODE_NAK;
    end
  end
endmodule

// File: rtl/uorx_byte_path.sv
module uorx_byte_path #(
  parameter int BUF_BYTES = 64,
  localparam int CNT_W    = $clog2(BUF_BYTES + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       active,
  input  logic       store,
  input  logic       rx_valid,
  output logic       rx_ready,
  input  logic [7:0] rx_data,
  output logic       fifo_wr_valid,
  input  logic       fifo_wr_ready,
  output logic [7:0] fifo_wr_data,
  output logic       overflow
);
  logic [CNT_W-1:0] count_q;
  logic             ovf_q;
  logic             room;
  logic             write_ok;
  logic             take;

  assign room          = (count_q < CNT_W'(BUF_BYTES));
  assign write_ok      = active && store && room && !ovf_q;
  assign fifo_wr_valid = rx_valid && write_ok;
  assign fifo_wr_data  = rx_data;
  assign rx_ready      = active && (!write_ok || fifo_wr_ready);
  assign take          = rx_valid && rx_ready;
  assign overflow      = ovf_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
      ovf_q   <= 1'b0;
    end else if (start) begin
      count_q <= '0;
      ovf_q   <= 1'b0;
    end else if (take && write_ok) begin
      count_q <= count_q + 1'b1;
    end else if (take && active && store && !room) begin
      ovf_q <= 1'b1;
    end
  end

  // R9: once a packet has overflowed it stays overflowed until the next token
  a_r9_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !start) |=> ovf_q);
  // R12: back-pressure on the FIFO side reaches the byte stream while storing
  a_r12_stall_on_fifo: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_wr_valid && !fifo_wr_ready) |-> !take);
endmodule

// File: rtl/uorx_ep_regs.sv
module uorx_ep_regs
  import uorx_pkg::*;
#(
  parameter int NUM_EP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EP-1:0] set_full,
  input  logic [NUM_EP-1:0] set_pend,
  input  logic              rd_en,
  input  logic              rd_sel,
  input  logic              clr_en,
  input  logic [NUM_EP-1:0] clr_mask,
  output logic [NUM_EP-1:0] full,
  output logic [NUM_EP-1:0] rdata,
  output logic              irq
);
  logic [NUM_EP-1:0] full_q;
  logic [NUM_EP-1:0] pend_q;
  logic [NUM_EP-1:0] full_clr;
  logic [NUM_EP-1:0] pend_clr;

  assign full_clr = clr_en ? clr_mask : '0;
  assign pend_clr = (rd_en && rd_sel == SEL_PENDING) ? '1 : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= '0;
      pend_q <= '0;
      rdata  <= '0;
    end else begin
      full_q <= (full_q & ~full_clr) | set_full;
      pend_q <= (pend_q & ~pend_clr) | set_pend;
      if (rd_en) rdata <= (rd_sel == SEL_FULL) ? full_q : pend_q;
    end
  end

  assign full = full_q;
  assign irq  = |pend_q;

  // R5/R6: a buffer marked full is visible the next cycle
  a_r6_full_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_full) |=> ((full_q & $past(set_full)) == $past(set_full)));
  // R10: reading the interrupt register empties it unless a new bit arrives
  a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_sel == SEL_PENDING && set_pend == '0) |=> (pend_q == '0));
endmodule

// File: rtl/usb_out_rx_handler.sv
module usb_out_rx_handler
  import uorx_pkg::*;
#(
  parameter int NUM_EP    = 4,
  parameter int BUF_BYTES = 64,
  parameter int ADDR_W    = 7,
  localparam int EPW      = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] dev_addr,
  input  logic [NUM_EP-1:0] ep_enable,
  input  logic [NUM_EP-1:0] ep_iso,
  input  logic              tok_valid,
  input  logic [ADDR_W-1:0] tok_addr,
  input  logic [3:0]        tok_ep,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [7:0]        rx_data,
  input  logic              pkt_end,
  input  logic              pkt_good,
  output logic              fifo_wr_valid,
  input  logic              fifo_wr_ready,
  output logic [EPW-1:0]    fifo_wr_ep,
  output logic [7:0]        fifo_wr_data,
  output logic              fifo_commit,
  output logic              fifo_drop,
  output logic              hs_ack,
  output logic              hs_nak,
  input  logic              reg_rd_en,
  input  logic              reg_sel,
  output logic [NUM_EP-1:0] reg_rdata,
  input  logic              reg_clr_en,
  input  logic [NUM_EP-1:0] reg_clr_mask,
  output logic              irq
);
  rx_state_e         state_q;
  rx_mode_e          mode_q;
  rx_mode_e          tok_mode;
  logic              iso_q;
  logic              tok_iso;
  logic [EPW-1:0]    ep_q;
  logic [NUM_EP-1:0] full;
  logic [NUM_EP-1:0] ep_sel;
  logic [NUM_EP-1:0] set_vec;
  logic              tok_fire;
  logic              end_fire;
  logic              overflow;
  logic              good_store;
  logic              hs_ack_q, hs_nak_q, commit_q, drop_q;

  uorx_token_filter #(.NUM_EP(NUM_EP), .ADDR_W(ADDR_W)) u_filter (
    .dev_addr (dev_addr),
    .tok_addr (tok_addr),
    .tok_ep   (tok_ep),
    .ep_enable(ep_enable),
    .ep_iso   (ep_iso),
    .ep_full  (full),
    .mode     (tok_mode),
    .iso      (tok_iso)
  );

  assign tok_fire   = (state_q == ST_IDLE) && tok_valid;
  assign end_fire   = (state_q == ST_DATA) && pkt_end;
  assign good_store = (mode_q == MODE_STORE) && pkt_good && !overflow;

  uorx_byte_path #(.BUF_BYTES(BUF_BYTES)) u_bytes (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (tok_fire),
    .active       (state_q == ST_DATA),
    .store        (mode_q == MODE_STORE),
    .rx_valid     (rx_valid),
    .rx_ready     (rx_ready),
    .rx_data      (rx_data),
    .fifo_wr_valid(fifo_wr_valid),
    .fifo_wr_ready(fifo_wr_ready),
    .fifo_wr_data (fifo_wr_data),
    .overflow     (overflow)
  );

  always_comb begin
    for (int i = 0; i < NUM_EP; i++) ep_sel[i] = (ep_q == EPW'(i));
  end

  // isochronous: update at the end edge; handshaking: one cycle after ACK
  assign set_vec = ((end_fire && good_store && iso_q) || state_q == ST_POST) ? ep_sel : '0;

  uorx_ep_regs #(.NUM_EP(NUM_EP)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_full(set_vec),
    .set_pend(set_vec),
    .rd_en   (reg_rd_en),
    .rd_sel  (reg_sel),
    .clr_en  (reg_clr_en),
    .clr_mask(reg_clr_mask),
    .full    (full),
    .rdata   (reg_rdata),
    .irq     (irq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      mode_q   <= MODE_SKIP;
      iso_q    <= 1'b0;
      ep_q     <= '0;
      hs_ack_q <= 1'b0;
      hs_nak_q <= 1'b0;
      commit_q <= 1'b0;
      drop_q   <= 1'b0;
    end else begin
      hs_ack_q <= 1'b0;
      hs_nak_q <= 1'b0;
      commit_q <= 1'b0;
      drop_q   <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (tok_valid) begin
          mode_q  <= tok_mode;
          iso_q   <= tok_iso;
          ep_q    <= tok_ep[EPW-1:0];
          state_q <= ST_DATA;
        end
        ST_DATA: if (pkt_end) begin
          hs_ack_q <= good_store && !iso_q;
          hs_nak_q <= (mode_q == MODE_NAK) && pkt_good;
          commit_q <= good_store;
          drop_q   <= (mode_q == MODE_STORE) && !good_store;
          state_q  <= (good_store && !iso_q) ? ST_POST : ST_IDLE;
        end
        ST_POST: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign hs_ack      = hs_ack_q;
  assign hs_nak      = hs_nak_q;
  assign fifo_commit = commit_q;
  assign fifo_drop   = drop_q;
  assign fifo_wr_ep  = ep_q;

  // R4/R7: at most one handshake kind at a time
  a_r4_one_handshake: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_ack && hs_nak));
  // R3: FIFO writes only in a storing data phase
  a_r3_write_when_storing: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr_valid |-> (state_q == ST_DATA && mode_q == MODE_STORE));
  // R5: isochronous transactions never acknowledge
  a_r5_iso_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
    hs_ack |-> !iso_q);
  // R8: a dropped packet is never answered
  a_r8_drop_silent: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_drop |-> (!hs_ack && !hs_nak && !fifo_commit));
  // R6: the status update follows the ACK by one cycle
  a_r6_post_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    hs_ack |-> (state_q == ST_POST));
  // R12: no byte is taken outside a data phase
  a_r12_idle_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_DATA) |-> !rx_ready);
endmodule

// File: tb/usb_out_rx_handler_bench.sv
module usb_out_rx_handler_bench;
  localparam int NUM_EP = 4;
  localparam int BUF_BYTES = 8;
  localparam int ADDR_W = 7;
  localparam int EPW = 2;
  localparam logic [6:0] MY_ADDR = 7'h2A;

  logic clk = 0;
  logic rst_n = 0;
  logic tok_valid = 0;
  logic [6:0] tok_addr = 0;
  logic [3:0] tok_ep = 0;
  logic rx_valid = 0;
  logic [7:0] rx_data = 0;
  logic pkt_end = 0, pkt_good = 0;
  logic reg_rd_en = 0, reg_sel = 0, reg_clr_en = 0;
  logic [3:0] reg_clr_mask = 0;
  logic rx_ready, fifo_wr_valid, fifo_commit, fifo_drop, hs_ack, hs_nak, irq;
  logic fifo_wr_ready;
  logic [EPW-1:0] fifo_wr_ep;
  logic [7:0] fifo_wr_data;
  logic [3:0] reg_rdata;
  int rdy_mode = 0;
  logic [3:0] pat = 0;
  int n_checks = 0, n_errors = 0;
  logic [15:0] exp_q[$];

  always #5 clk = ~clk;
  always @(posedge clk) pat <= pat + 1'b1;
  assign fifo_wr_ready = (rdy_mode == 0) ? 1'b1 : (rdy_mode == 1) ? (pat[0] | pat[1]) : 1'b0;

  usb_out_rx_handler #(.NUM_EP(NUM_EP), .BUF_BYTES(BUF_BYTES), .ADDR_W(ADDR_W)) u_usb_out_rx_handler (
    .clk(clk), .rst_n(rst_n), .dev_addr(MY_ADDR), .ep_enable(4'b0111), .ep_iso(4'b0100),
    .tok_valid(tok_valid), .tok_addr(tok_addr), .tok_ep(tok_ep),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .pkt_end(pkt_end), .pkt_good(pkt_good),
    .fifo_wr_valid(fifo_wr_valid), .fifo_wr_ready(fifo_wr_ready), .fifo_wr_ep(fifo_wr_ep),
    .fifo_wr_data(fifo_wr_data), .fifo_commit(fifo_commit), .fifo_drop(fifo_drop),
    .hs_ack(hs_ack), .hs_nak(hs_nak),
    .reg_rd_en(reg_rd_en), .reg_sel(reg_sel), .reg_rdata(reg_rdata),
    .reg_clr_en(reg_clr_en), .reg_clr_mask(reg_clr_mask), .irq(irq)
  );

  task automatic chk(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: pop the scoreboard on every FIFO write (R3)
  always @(negedge clk) begin
    if (rst_n && fifo_wr_valid && fifo_wr_ready) begin
      if (exp_q.size() == 0) chk("R3 unexpected write", {8'd0, fifo_wr_ep, fifo_wr_data}, -1);
      else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        chk("R3 write ep/data", {6'd0, fifo_wr_ep, fifo_wr_data}, int'(e));
      end
    end
  end

  task automatic tick; @(posedge clk); #1; endtask

  task automatic token(logic [6:0] a, logic [3:0] ep);
    tok_valid = 1; tok_addr = a; tok_ep = ep;
    tick();
    tok_valid = 0;
  endtask

  task automatic send_bytes(int ep, int n, int base, int n_store);
    for (int i = 0; i < n; i++) begin
      logic acc;
      if (i < n_store) exp_q.push_back(16'((ep << 8) | ((base + i) & 8'hFF)));
      rx_valid = 1; rx_data = 8'(base + i);
      do begin
        @(negedge clk); acc = rx_ready;
        tick();
      end while (!acc);
    end
    rx_valid = 0;
  endtask

  // returns {hs_ack,hs_nak,commit,drop,irq_after_E,irq_after_E1}
  task automatic end_pkt(logic good, output logic [5:0] r);
    pkt_end = 1; pkt_good = good;
    tick();
    pkt_end = 0;
    @(negedge clk);
    r[5:1] = {hs_ack, hs_nak, fifo_commit, fifo_drop, irq};
    @(negedge clk);
    r[0] = irq;
    chk("R3 scoreboard drained", exp_q.size(), 0);
  endtask

  task automatic read_reg(logic sel, output logic [3:0] v);
    reg_rd_en = 1; reg_sel = sel;
    tick();
    reg_rd_en = 0;
    @(negedge clk); v = reg_rdata;
  endtask

  initial begin
    #2_000_000;
    n_errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    logic [5:0] r;
    logic [3:0] v;
    repeat (3) tick();
    rst_n = 1;
    @(negedge clk);
    chk("R12 reset rx_ready", rx_ready, 0);
    chk("R10 reset irq", irq, 0);
    chk("R4 reset hs", {hs_ack, hs_nak}, 0);
    read_reg(1'b0, v); chk("R10 reset pending", v, 0);

    // R1 wrong address
    tick(); token(7'h11, 4'd0); send_bytes(0, 3, 8'h10, 0); end_pkt(1, r);
    chk("R1 wrong address", r, 0);
    // R1 endpoint number out of range
    token(MY_ADDR, 4'd5); send_bytes(0, 2, 8'h18, 0); end_pkt(1, r);
    chk("R1 endpoint out of range", r, 0);
    // R2 disabled endpoint
    token(MY_ADDR, 4'd3); send_bytes(3, 3, 8'h20, 0); end_pkt(1, r);
    chk("R2 disabled endpoint", r, 0);
    read_reg(1'b1, v); chk("R2 status untouched", v, 0);

    // R3 R4 R6 store on ep0
    tick(); token(MY_ADDR, 4'd0); send_bytes(0, 5, 8'h30, 5); end_pkt(1, r);
    chk("R4 ack+commit, R6 irq late", r, 6'b101001);
    read_reg(1'b0, v); chk("R10 pending ep0", v, 4'b0001);
    @(negedge clk); chk("R10 irq drops after read", irq, 0);
    read_reg(1'b1, v); chk("R11 status ep0 full", v, 4'b0001);

    // R7 NAK on full ep0, R12 ready not gated by FIFO
    tick(); token(MY_ADDR, 4'd0); rdy_mode = 2;
    @(negedge clk); chk("R12 nak phase ready", rx_ready, 1);
    tick(); send_bytes(0, 2, 8'h40, 0); end_pkt(1, r);
    chk("R7 nak on full", r, 6'b010000);
    // R8 NAK endpoint with bad packet
    token(MY_ADDR, 4'd0); send_bytes(0, 2, 8'h44, 0); end_pkt(0, r);
    chk("R8 bad packet no nak", r, 0);
    rdy_mode = 0;

    // R11 clear and store again, R12 back-pressure
    reg_clr_en = 1; reg_clr_mask = 4'b0001; tick(); reg_clr_en = 0;
    read_reg(1'b1, v); chk("R11 status cleared", v, 0);
    tick(); token(MY_ADDR, 4'd0); rdy_mode = 2;
    @(negedge clk); chk("R12 store stalled", rx_ready, 0);
    rdy_mode = 0;
    @(negedge clk); chk("R12 store ready", rx_ready, 1);
    rdy_mode = 1;
    tick(); send_bytes(0, 6, 8'h50, 6); rdy_mode = 0; end_pkt(1, r);
    chk("R11 store after clear", r, 6'b101001);
    read_reg(1'b0, v); chk("R10 pending ep0 again", v, 4'b0001);

    // R5 isochronous ep2
    tick(); token(MY_ADDR, 4'd2); send_bytes(2, 3, 8'h60, 3); end_pkt(1, r);
    chk("R5 iso no hs, irq early", r, 6'b001011);
    read_reg(1'b0, v); chk("R5 pending ep2", v, 4'b0100);
    // R7 iso full: nothing
    tick(); token(MY_ADDR, 4'd2); send_bytes(2, 3, 8'h68, 0); end_pkt(1, r);
    chk("R7 iso full silent", r, 0);

    // R8 bad packet on ep1
    token(MY_ADDR, 4'd1); send_bytes(1, 3, 8'h70, 3); end_pkt(0, r);
    chk("R8 bad packet drop", r, 6'b000100);
    read_reg(1'b1, v); chk("R8 status unchanged", v, 4'b0101);
    // R9 overflow
    tick(); token(MY_ADDR, 4'd1); send_bytes(1, 10, 8'h80, BUF_BYTES); end_pkt(1, r);
    chk("R9 overflow dropped", r, 6'b000100);
    read_reg(1'b1, v); chk("R9 status unchanged", v, 4'b0101);

    // R10 pending set in the same edge as a read
    tick(); token(MY_ADDR, 4'd1); send_bytes(1, 2, 8'h90, 2);
    pkt_end = 1; pkt_good = 1; tick(); pkt_end = 0;
    reg_rd_en = 1; reg_sel = 0; tick(); reg_rd_en = 0;
    @(negedge clk);
    chk("R10 read sees old pending", reg_rdata, 0);
    chk("R10 new bit survives read", irq, 1);
    chk("R3 scoreboard drained", exp_q.size(), 0);
    read_reg(1'b0, v); chk("R10 pending ep1", v, 4'b0010);
    read_reg(1'b1, v); chk("R11 status all stored", v, 4'b0111);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule